// File: doc/BRIEF.md
# Byte-Lane SRAM Window Decoder

This block sits between a 32-bit processor bus and an SRAM array made of four 8-bit byte lanes. The processor supplies a word address with no byte-offset bits, four active-low lane enables, an active-low write signal, a memory/IO indicator and an active-low address strobe. The block compares the upper address bits against a fixed 256 KiB window. Inside the window it asserts one active-low chip select, an active-low output enable for reads, and an active-low write strobe for each enabled lane during writes. It also passes the 16-bit word address to the array.

A behavioural model of the four-lane array is part of the top level. It lets reads and writes be observed at the block's ports. Each lane stores only the bytes it is strobed for. On a read the model returns the whole 32-bit word, and the processor keeps the lanes it enabled. Because the model's depth is a parameter, large windows can be decoded without building large storage.

Top module: `byteLaneDecoder`

## Requirements
- R1: When the address strobe `adsN` is high, or `mioSel` is low (IO cycle), `csN`, `oeN`, every bit of `weN` and `memAddr` stay inactive (1, 1, all ones, zero).
- R2: `csN` is low only during a memory cycle with `adsN` low and `cpuAddr[31:18]` equal to bits 31:18 of the window base 0x02000000, so the window covers 0x02000000 through 0x0203FFFF.
- R3: Lane i (lane 0 = data bits 7:0, lane 3 = bits 31:24) has write strobe `weN[i]` low exactly when the chip is selected, `wrN` is low and `beN[i]` is low. Byte, halfword (`beN` 1100 or 0011) and word (0000) writes each strobe only their own lanes.
- R4: `oeN` is low exactly for selected cycles with `wrN` high, and never while any `weN` bit is low.
- R5: While selected, `memAddr` equals processor address bits 17:2, so `memAddr[0]` follows processor address bit 2 (byte address 0x02000004 gives `memAddr` 1, 0x0203FFFC gives 0xFFFF).
- R6: Accesses at 0x01FFFFFC and at 0x02040000 assert no select. A write there leaves the array contents unchanged.
- R7: On a strobed write, the array updates only the lanes whose `weN` bit is low, and keeps the other bytes of that word.
- R8: While `csN` and `oeN` are both low, `rdData` carries all four lanes of the addressed word. Otherwise `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for array writes |
| cpuAddr | input | 30 | Processor word address, bits 31:2 |
| beN | input | 4 | Active-low lane enables, bit i for data bits 8i+7:8i |
| wrN | input | 1 | Active-low write, high for read |
| mioSel | input | 1 | High for a memory cycle, low for IO |
| adsN | input | 1 | Active-low address strobe |
| wrData | input | 32 | Write data from the processor |
| rdData | output | 32 | Read data returned by the array |
| csN | output | 1 | Active-low array chip select |
| oeN | output | 1 | Active-low output enable |
| weN | output | 4 | Active-low per-lane write strobes |
| memAddr | output | 16 | Word address to the array |

## Verification
The bench builds the block with the default 32-bit address, 32-bit data, 16-bit word address and the 0x02000000 base. It shrinks the behavioural array to 16 words (`MODEL_ADDR_W` = 4). The full decode path is therefore exercised at both ends of the window: memAddr 0 and 0xFFFF, and the first words just outside the window. The reference byte map stays small enough to track every lane. With only 16 words, a rejected write just above the window would alias onto word 0 if it leaked through. Reading word 0 back then shows whether the decode let it through.

// File: rtl/laneDecPkg.sv
package laneDecPkg;
  localparam int BYTE_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic addrValid;  // selected cycle, address forwarded
    logic wrEn;       // selected write cycle
  } ctrlStrobeT;
endpackage

// File: rtl/laneDecCtrl.sv
module laneDecCtrl
  import laneDecPkg::*;
#(
  parameter int TAG_W = 14,
  parameter logic [TAG_W-1:0] WIN_TAG = '0
) (
  input  logic [TAG_W-1:0] addrTag,
  input  logic             mioSel,
  input  logic             adsN,
  input  logic             wrN,
  output ctrlStrobeT       strb,
  output logic             csN,
  output logic             oeN
);
  logic tagHit;
  logic cycleHit;

  always_comb begin
    tagHit   = (addrTag == WIN_TAG);
    cycleHit = tagHit && mioSel && !adsN;
    strb.addrValid = cycleHit;
    strb.wrEn      = cycleHit && !wrN;
    csN = !cycleHit;
    oeN = !(cycleHit && wrN);
  end
endmodule

// File: rtl/laneDecPath.sv
module laneDecPath
  import laneDecPkg::*;
#(
  parameter int WORD_ADDR_W = 16,
  parameter int LANES       = 4
) (
  input  logic [WORD_ADDR_W-1:0] wordAddr,
  input  logic [LANES-1:0]       beN,
  input  ctrlStrobeT             strb,
  output logic [WORD_ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]       weN
);
  assign memAddr = strb.addrValid ? wordAddr : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // a lane strobes only when its enable and the write are both low
    assign weN[i] = !(strb.wrEn && !beN[i]);
  end
endmodule

// File: rtl/laneMemArray.sv
module laneMemArray
  import laneDecPkg::*;
#(
  parameter int LANES        = 4,
  parameter int MODEL_ADDR_W = 8,
  localparam int DATA_W      = LANES * BYTE_W,
  localparam int DEPTH       = 1 << MODEL_ADDR_W
) (
  input  logic                    clk,
  input  logic                    csN,
  input  logic                    oeN,
  input  logic [LANES-1:0]        weN,
  input  logic [MODEL_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]       wrData,
  output logic [DATA_W-1:0]       rdData
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (!csN && !weN[i]) laneMem[addr] <= wrData[i*BYTE_W +: BYTE_W];
    end

    assign rdData[i*BYTE_W +: BYTE_W] = (!csN && !oeN) ? laneMem[addr] : '0;
  end
endmodule

// File: rtl/byteLaneDecoder.sv
module byteLaneDecoder
  import laneDecPkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          DATA_W       = 32,
  parameter int          WORD_ADDR_W  = 16,
  parameter logic [31:0] WIN_BASE     = 32'h0200_0000,
  parameter int          MODEL_ADDR_W = 8,
  parameter int          LANES        = DATA_W / BYTE_W
) (
  input  logic                   clk,
  input  logic [ADDR_W-1:2]      cpuAddr,
  input  logic [LANES-1:0]       beN,
  input  logic                   wrN,
  input  logic                   mioSel,
  input  logic                   adsN,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  output logic                   csN,
  output logic                   oeN,
  output logic [LANES-1:0]       weN,
  output logic [WORD_ADDR_W-1:0] memAddr
);
  localparam int TAG_LO = WORD_ADDR_W + 2;
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:TAG_LO];

  ctrlStrobeT strb;

  laneDecCtrl #(.TAG_W(TAG_W), .WIN_TAG(WIN_TAG)) u_ctrl (
    .addrTag(cpuAddr[ADDR_W-1:TAG_LO]),
    .mioSel (mioSel),
    .adsN   (adsN),
    .wrN    (wrN),
    .strb   (strb),
    .csN    (csN),
    .oeN    (oeN)
  );

  laneDecPath #(.WORD_ADDR_W(WORD_ADDR_W), .LANES(LANES)) u_path (
    .wordAddr(cpuAddr[TAG_LO-1:2]),
    .beN     (beN),
    .strb    (strb),
    .memAddr (memAddr),
    .weN     (weN)
  );

  laneMemArray #(.LANES(LANES), .MODEL_ADDR_W(MODEL_ADDR_W)) u_mem (
    .clk   (clk),
    .csN   (csN),
    .oeN   (oeN),
    .weN   (weN),
    .addr  (memAddr[MODEL_ADDR_W-1:0]),
    .wrData(wrData),
    .rdData(rdData)
  );
endmodule

// File: rtl/byteLaneDecoderChk.sv
module byteLaneDecoderChk #(
  parameter int          ADDR_W      = 32,
  parameter int          WORD_ADDR_W = 16,
  parameter logic [31:0] WIN_BASE    = 32'h0200_0000,
  parameter int          LANES       = 4
) (
  input logic                   clk,
  input logic [ADDR_W-1:2]      cpuAddr,
  input logic [LANES-1:0]       beN,
  input logic                   wrN,
  input logic                   mioSel,
  input logic                   adsN,
  input logic                   csN,
  input logic                   oeN,
  input logic [LANES-1:0]       weN,
  input logic [WORD_ADDR_W-1:0] memAddr
);
  localparam int TAG_LO = WORD_ADDR_W + 2;

  always_ff @(posedge clk) begin
    if (adsN || !mioSel)
      a_r1_idle_quiet: assert (csN && oeN && (&weN) && memAddr == '0);
    if (!csN)
      a_r2_r5_window_addr: assert ({WIN_BASE[ADDR_W-1:TAG_LO], memAddr} == cpuAddr);
    if (!oeN)
      a_r4_oe_excl_write: assert ((&weN) && wrN && !csN);
    for (int i = 0; i < LANES; i++) begin
      if (!weN[i])
        a_r3_lane_needs_enable: assert (!beN[i] && !wrN && !csN);
      if (!csN && !wrN && !beN[i])
        a_r3_lane_strobed: assert (!weN[i]);
    end
  end
endmodule

bind byteLaneDecoder byteLaneDecoderChk #(
  .ADDR_W(ADDR_W), .WORD_ADDR_W(WORD_ADDR_W), .WIN_BASE(WIN_BASE), .LANES(LANES)
) u_chk (
  .clk(clk), .cpuAddr(cpuAddr), .beN(beN), .wrN(wrN), .mioSel(mioSel),
  .adsN(adsN), .csN(csN), .oeN(oeN), .weN(weN), .memAddr(memAddr)
);

// File: tb/byteLaneDecoder_tb.sv
module byteLaneDecoder_tb;
  localparam int WORDS = 16;

  typedef struct packed {
    logic        isWr;
    logic [3:0]  word;
    logic [3:0]  be;
    logic [31:0] data;
  } vecT;

  localparam int NVEC = 15;
  localparam vecT VECS [NVEC] = '{
    '{1'b1, 4'd0, 4'b0000, 32'h1122_3344},  // word write
    '{1'b1, 4'd1, 4'b0000, 32'h5566_7788},
    '{1'b1, 4'd0, 4'b1110, 32'h0000_00AA},  // byte lanes 0..3
    '{1'b1, 4'd0, 4'b1101, 32'h0000_BB00},
    '{1'b1, 4'd0, 4'b1011, 32'h00CC_0000},
    '{1'b1, 4'd0, 4'b0111, 32'hDD00_0000},
    '{1'b1, 4'd1, 4'b1100, 32'h0000_1357},  // halfword low
    '{1'b1, 4'd1, 4'b0011, 32'h2468_0000},  // halfword high
    '{1'b0, 4'd0, 4'b0000, 32'h0},
    '{1'b0, 4'd1, 4'b0000, 32'h0},
    '{1'b0, 4'd1, 4'b1110, 32'h0},
    '{1'b0, 4'd0, 4'b0011, 32'h0},
    '{1'b1, 4'd5, 4'b0000, 32'hCAFE_F00D},
    '{1'b1, 4'd5, 4'b1011, 32'h0077_0000},
    '{1'b0, 4'd5, 4'b0000, 32'h0}
  };

  logic        clk = 1'b0;
  logic [31:2] cpuAddr = '0;
  logic [3:0]  beN = 4'hF;
  logic        wrN = 1'b1;
  logic        mioSel = 1'b1;
  logic        adsN = 1'b1;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        csN, oeN;
  logic [3:0]  weN;
  logic [15:0] memAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] refMem [WORDS][4];

  always #10 clk = ~clk;

  byteLaneDecoder #(.MODEL_ADDR_W(4)) u_dut (
    .clk(clk), .cpuAddr(cpuAddr), .beN(beN), .wrN(wrN), .mioSel(mioSel),
    .adsN(adsN), .wrData(wrData), .rdData(rdData), .csN(csN), .oeN(oeN),
    .weN(weN), .memAddr(memAddr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [31:0] byteAddr, input logic [3:0] be,
                       input logic [31:0] d, input logic mio, input logic ads);
    @(negedge clk);
    cpuAddr = byteAddr[31:2];
    beN = be; wrN = !wr; mioSel = mio; adsN = ads; wrData = d;
    #2;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  logic [63:0] quiet;
  assign quiet = {48'h0, 1'b1, 1'b1, 4'hF, 16'h0} ;

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // idle bus: R1, R8
    drive(1'b0, 32'h0200_0000, 4'h0, 32'h0, 1'b1, 1'b1);
    chk("R1 idle", {csN, oeN, weN, memAddr}, {1'b1, 1'b1, 4'hF, 16'h0});
    chk("R8 idle rdData", rdData, 32'h0);
    settle();

    for (int v = 0; v < NVEC; v++) begin
      vecT e = VECS[v];
      logic [31:0] ba = 32'h0200_0000 + {e.word, 2'b00};
      drive(e.isWr, ba, e.be, e.data, 1'b1, 1'b0);
      chk(e.isWr ? "R3 R5 write strobes" : "R4 R5 read enables",
          {csN, oeN, weN, memAddr},
          {1'b0, !e.isWr ? 1'b0 : 1'b1, e.isWr ? e.be : 4'hF, 12'h0, e.word});
      if (e.isWr) begin
        for (int i = 0; i < 4; i++)
          if (!e.be[i]) refMem[e.word][i] = e.data[i*8 +: 8];
      end else begin
        for (int i = 0; i < 4; i++)
          if (!e.be[i]) chk("R7 R8 lane readback", rdData[i*8 +: 8], refMem[e.word][i]);
      end
      settle();
    end

    // IO cycle inside the window: R1
    drive(1'b1, 32'h0200_0000, 4'h0, 32'hDEAD_BEEF, 1'b0, 1'b0);
    chk("R1 io cycle", {csN, oeN, weN, memAddr}, {1'b1, 1'b1, 4'hF, 16'h0});
    settle();
    // just below the window: R6
    drive(1'b1, 32'h01FF_FFFC, 4'h0, 32'hDEAD_BEEF, 1'b1, 1'b0);
    chk("R6 below window", {csN, oeN, weN, memAddr}, {1'b1, 1'b1, 4'hF, 16'h0});
    settle();
    // just above the window: R6 (would alias word 0 in the model)
    drive(1'b1, 32'h0204_0000, 4'h0, 32'hDEAD_BEEF, 1'b1, 1'b0);
    chk("R6 above window", {csN, oeN, weN, memAddr}, {1'b1, 1'b1, 4'hF, 16'h0});
    settle();
    drive(1'b0, 32'h0200_0000, 4'h0, 32'h0, 1'b1, 1'b0);
    chk("R6 word0 unchanged", rdData,
        {refMem[0][3], refMem[0][2], refMem[0][1], refMem[0][0]});
    settle();
    // top of window: R2, R5
    drive(1'b0, 32'h0203_FFFC, 4'h0, 32'h0, 1'b1, 1'b0);
    chk("R2 R5 top of window", {csN, oeN, weN, memAddr}, {1'b0, 1'b0, 4'hF, 16'hFFFF});
    settle();
    // address bit 2 drives memAddr bit 0: R5
    drive(1'b0, 32'h0200_0004, 4'h0, 32'h0, 1'b1, 1'b0);
    chk("R5 bit2 to bit0", memAddr, 16'h0001);
    settle();
    drive(1'b0, 32'h0200_0000, 4'h0, 32'h0, 1'b1, 1'b1);
    chk("R1 return to idle", {csN, oeN, weN, memAddr}, {1'b1, 1'b1, 4'hF, 16'h0});
    chk("R8 rdData zero when idle", rdData, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule